// File: doc/BRIEF.md
# Triggered Delayed Pulse-Train Generator

This block drives one output line. When a trigger strobe is accepted, it waits a programmable number of reference-clock cycles. It then emits a train of pulses. The high time, the rising-edge spacing and the number of pulses are each set on their own. A continuous mode keeps the train running until software aborts it or the channel is disabled. All timing is counted in whole cycles of the reference clock. With the default 100 MHz clock, a 34-bit delay field covers 120 s and a 27-bit width/period field covers 1 s.

The settings are captured at the moment a trigger is accepted, so software may reprogram the next train while the current one runs. A trigger that arrives while the block is busy is dropped and recorded in a sticky flag. A setting that cannot be produced is refused at trigger time and recorded in a second sticky flag. Both sticky flags clear on abort.

Top module: `trig_pulse_train`

## Requirements
- R1: After reset, pulse_out, busy, done, missed and cfg_err are all 0.
- R2: If trig is high with en high on clock edge k while idle, and the settings are valid, then pulse_out first goes high at edge k+cfg_delay. A delay of D cycles means the rise happens D edges after the accepting edge, with D ≥ 1.
- R3: Each pulse stays high for exactly cfg_width cycles. Successive rising edges are exactly cfg_period cycles apart.
- R4: In finite mode (cfg_cont = 0), a train contains exactly cfg_count_m1 + 1 pulses. The count register holds the pulse count minus one, so values 0 to 65535 give 1 to 65536 pulses.
- R5: done is high for exactly one cycle. It is set on the same edge where the last pulse of a finite train falls, and busy drops on that same edge.
- R6: With cfg_cont = 1, pulses repeat without limit and done never rises.
- R7: A trigger seen while busy does not change the running train. It sets the sticky flag missed.
- R8: The settings are captured when a trigger is accepted. Changing any cfg input during a train has no effect on that train.
- R9: A trigger taken while idle with cfg_width = 0, cfg_width ≥ cfg_period, or cfg_delay = 0 starts nothing. It sets the sticky flag cfg_err.
- R10: abort high on an edge returns the block to idle with pulse_out low, clears missed and cfg_err, and gives no done. While en is low, triggers are ignored and any train in progress stops.
- R11: busy is high from the accepting edge until the train ends. pulse_out is never high unless busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| trig | input | 1 | Synchronous trigger strobe |
| abort | input | 1 | Software abort; also clears sticky flags |
| cfg_delay | input | DW | Trigger-to-first-rise delay in cycles |
| cfg_width | input | TW | Pulse high time in cycles |
| cfg_period | input | TW | Rising-edge spacing in cycles |
| cfg_count_m1 | input | CW | Pulse count minus one |
| cfg_cont | input | 1 | Continuous mode |
| pulse_out | output | 1 | Pulse line |
| busy | output | 1 | Delay or train in progress |
| done | output | 1 | One-cycle end-of-train strobe |
| missed | output | 1 | Sticky: trigger dropped while busy |
| cfg_err | output | 1 | Sticky: invalid settings refused |

## Verification
The bound assertions check on every cycle the rules that relate flags to one another:
- pulse_out only while busy;
- done is a single cycle, with busy and pulse_out already low;
- a busy-time trigger sets missed;
- missed persists until abort;
- abort empties the block.

Exact timing is shown only by the bench's scenarios: the delay to the first rise, the high time, the spacing, the pulse count, and the immunity to mid-train writes. The bench compares every cycle of each train against an expected waveform built from the requested numbers.

// File: rtl/trig_pulse_train.sv
module trig_pulse_train #(
  parameter int DW = 34,
  parameter int TW = 27,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trig,
  input  logic          abort,
  input  logic [DW-1:0] cfg_delay,
  input  logic [TW-1:0] cfg_width,
  input  logic [TW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_count_m1,
  input  logic          cfg_cont,
  output logic          pulse_out,
  output logic          busy,
  output logic          done,
  output logic          missed,
  output logic          cfg_err
);
  typedef enum logic [1:0] {IDLE, DELAY, TRAIN} st_t;
  st_t st;

  logic [DW-1:0] dly_cnt;
  logic [TW-1:0] ph, w_q, p_q;
  logic [CW-1:0] rem;
  logic          cont_q;

  wire cfg_bad = (cfg_width == '0) || (cfg_width >= cfg_period) || (cfg_delay == '0);
  wire last    = (rem == '0) && !cont_q;

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      dly_cnt   <= '0;
      ph        <= '0;
      w_q       <= '0;
      p_q       <= '0;
      rem       <= '0;
      cont_q    <= 1'b0;
      pulse_out <= 1'b0;
      done      <= 1'b0;
      missed    <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st        <= IDLE;
        pulse_out <= 1'b0;
        missed    <= 1'b0;
        cfg_err   <= 1'b0;
      end else if (!en) begin
        st        <= IDLE;
        pulse_out <= 1'b0;
      end else begin
        case (st)
          IDLE: if (trig) begin
            if (cfg_bad) cfg_err <= 1'b1;
            else begin
              dly_cnt <= cfg_delay;
              w_q     <= cfg_width;
              p_q     <= cfg_period;
              rem     <= cfg_count_m1;
              cont_q  <= cfg_cont;
              st      <= DELAY;
            end
          end
          DELAY: begin
            if (trig) missed <= 1'b1;
            if (dly_cnt == DW'(1)) begin
              st        <= TRAIN;
              pulse_out <= 1'b1;
              ph        <= TW'(1);
            end else begin
              dly_cnt <= dly_cnt - DW'(1);
            end
          end
          TRAIN: begin
            if (trig) missed <= 1'b1;
            ph <= ph + TW'(1);
            if (ph == w_q) begin
              pulse_out <= 1'b0;
              if (last) begin
                done <= 1'b1;
                st   <= IDLE;
              end
            end
            if (ph == p_q) begin
              pulse_out <= 1'b1;
              ph        <= TW'(1);
              rem       <= rem - CW'(1);
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

module trig_pulse_train_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic trig,
  input logic abort,
  input logic pulse_out,
  input logic busy,
  input logic done,
  input logic missed,
  input logic cfg_err
);
  // R11
  pulse_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> busy);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pulse_out));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy && en && !abort) |=> missed);
  // R7
  missed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missed && !abort) |=> missed);
  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !pulse_out && !missed && !cfg_err && !done));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !abort) |=> cfg_err);
endmodule

bind trig_pulse_train trig_pulse_train_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .abort(abort),
  .pulse_out(pulse_out), .busy(busy), .done(done),
  .missed(missed), .cfg_err(cfg_err)
);

// File: tb/trig_pulse_train_tb.sv
module trig_pulse_train_tb;
  localparam int CLK_NS = 10;
  localparam int DW = 34, TW = 27, CW = 16;

  logic clk = 0, rst_n = 0, en = 0, trig = 0, abort = 0, cfg_cont = 0;
  logic [DW-1:0] cfg_delay = '0;
  logic [TW-1:0] cfg_width = '0, cfg_period = '0;
  logic [CW-1:0] cfg_count_m1 = '0;
  logic pulse_out, busy, done, missed, cfg_err;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  trig_pulse_train #(.DW(DW), .TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .abort(abort),
    .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_period(cfg_period),
    .cfg_count_m1(cfg_count_m1), .cfg_cont(cfg_cont),
    .pulse_out(pulse_out), .busy(busy), .done(done),
    .missed(missed), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pulse(int j, int d, int w, int p, int n, bit cont);
    int q, r;
    if (j < d) return 0;
    q = (j - d) / p;
    r = (j - d) % p;
    return (cont || q < n) && (r < w);
  endfunction

  task automatic clear_flags();
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
  endtask

  task automatic set_cfg(int d, int w, int p, int n, bit cont);
    cfg_delay = DW'(d); cfg_width = TW'(w); cfg_period = TW'(p);
    cfg_count_m1 = CW'(n - 1); cfg_cont = cont;
  endtask

  task automatic fire();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  // R2 R3 R4 R5 R8 R11 (and R7 when poke is set, R6 when cont is set)
  task automatic run(int d, int w, int p, int n, bit cont, bit poke, int cont_len, string req);
    int fin, lim, bad, bj;
    logic [3:0] act, exv;
    fin = d + (n - 1) * p + w;
    lim = cont ? cont_len : fin + 2;
    bad = 0; bj = 0; act = '0; exv = '0;
    clear_flags();
    set_cfg(d, w, p, n, cont);
    fire();
    for (int j = 0; j <= lim; j++) begin
      logic [3:0] a, e;
      if (j > 0) @(negedge clk);
      if (poke && j == 2) begin
        set_cfg(1 + ($urandom % 9), 1, 2 + ($urandom % 5), 1 + ($urandom % 3), ~cont);
        trig = 1;
      end
      if (poke && j == 3) trig = 0;
      a = {pulse_out, busy, done, 1'b0};
      e = {exp_pulse(j, d, w, p, n, cont), cont ? 1'b1 : (j < fin),
           (!cont && j == fin), 1'b0};
      if (a != e && bad == 0) begin bj = j; act = a; exv = e; end
      if (a != e) bad++;
    end
    chk(bad == 0, req, $sformatf("waveform d=%0d w=%0d p=%0d n=%0d cont=%0d at j=%0d {pulse,busy,done}",
        d, w, p, n, cont, bj), act, exv);
    chk(missed == poke, poke ? "R7" : "R7", "missed flag", missed, poke);
    if (cont) begin
      @(negedge clk) abort = 1;
      @(negedge clk) abort = 0;
      chk(!pulse_out && !busy && !done && !missed, "R10", "state after abort",
          {pulse_out, busy, done, missed}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R1
    chk({pulse_out, busy, done, missed, cfg_err} == 0, "R1", "reset outputs",
        {pulse_out, busy, done, missed, cfg_err}, 0);
    rst_n = 1; en = 1;
    @(negedge clk);

    // R2 R3 R4 R5: minimum settings and directed cases
    run(1, 1, 2, 1, 0, 0, 0, "R2");
    run(3, 2, 3, 3, 0, 0, 0, "R3");
    run(5, 4, 5, 4, 0, 0, 0, "R4");
    run(2, 1, 7, 2, 0, 0, 0, "R5");

    // R8 R7: config writes and triggers during a train
    run(6, 2, 5, 3, 0, 1, 0, "R8");
    run(4, 3, 6, 2, 0, 1, 0, "R8");

    // R6: continuous mode ended by abort
    run(3, 2, 4, 1, 1, 0, 30, "R6");
    run(7, 1, 3, 1, 1, 1, 25, "R6");

    // R11: random trains
    for (int i = 0; i < 8; i++) begin
      int d, w, p, n;
      d = 1 + ($urandom % 20);
      w = 1 + ($urandom % 5);
      p = w + 1 + ($urandom % 4);
      n = 1 + ($urandom % 4);
      run(d, w, p, n, 0, 0, 0, "R11");
    end

    // R9: invalid settings refused
    clear_flags();
    set_cfg(4, 3, 3, 1, 0);
    fire();
    chk(cfg_err && !busy, "R9", "width==period refused {err,busy}", {cfg_err, busy}, 2);
    repeat (6) @(negedge clk);
    chk(!pulse_out && !busy && cfg_err, "R9", "no pulse after refusal",
        {pulse_out, busy, cfg_err}, 1);
    clear_flags();
    chk(!cfg_err, "R10", "abort clears cfg_err", cfg_err, 0);
    set_cfg(4, 0, 3, 1, 0);
    fire();
    chk(cfg_err && !busy, "R9", "width==0 refused {err,busy}", {cfg_err, busy}, 2);
    clear_flags();
    set_cfg(0, 1, 3, 1, 0);
    fire();
    chk(cfg_err && !busy, "R9", "delay==0 refused {err,busy}", {cfg_err, busy}, 2);

    // R10: en low ignores triggers and stops a train
    clear_flags();
    en = 0;
    set_cfg(2, 1, 3, 2, 0);
    fire();
    chk(!busy && !missed && !cfg_err, "R10", "trigger with en low {busy,missed,err}",
        {busy, missed, cfg_err}, 0);
    @(negedge clk) en = 1;
    set_cfg(2, 2, 4, 1, 1);
    fire();
    repeat (4) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(!busy && !pulse_out && !done, "R10", "en low stops train {busy,pulse,done}",
        {busy, pulse_out, done}, 0);
    repeat (5) @(negedge clk);
    chk(!pulse_out && !done, "R10", "stays stopped", {pulse_out, done}, 0);
    en = 1;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule